// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masks

This block watches a running BCD calendar clock and decides, once per second, whether a programmed alarm moment has arrived. Software programs four alarm bytes (seconds, minutes, hours, day of month). The top bit of each byte is a "don't care" mask. Setting masks from the day-of-month field downward widens the match, so that the alarm repeats monthly, daily, hourly, every minute or every second.

A hit sets a sticky alarm flag, which software clears by reading the status register. A hit also produces a one-cycle interrupt pulse, provided the alarm-enable bit is set. The clock counter that produces the BCD time and the one-second strobe lives outside this block.

The register port is a plain single-cycle control port. A write is taken in the cycle `wr_en` is high. A read issued with `rd_en` returns its data on `rd_data` one cycle later. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, the status register reads 0x00, the alarm seconds, minutes and hours bytes read 0x00, the alarm day byte reads 0x01, the enable register reads 0x00, and `alarm_irq` and `alarm_flag` are low.
- R2: The register map is 0 = status (read-only, writes ignored), 1 = alarm seconds, 2 = alarm minutes, 3 = alarm hours, 4 = alarm day, 5 = enable (only bit 7 is stored, other bits read 0), and 6 and 7 read 0x00. An accepted alarm byte is stored whole, including bit 7. Read data appears one cycle after `rd_en`.
- R3: A write to alarm seconds or minutes is accepted only when bits 6:0 hold valid BCD from 00 to 59 (ones digit at most 9). Otherwise the stored byte is unchanged.
- R4: A write to alarm hours is accepted only when bits 5:0 hold valid BCD from 00 to 23. Otherwise the stored byte is unchanged.
- R5: A write to alarm day is accepted only when bits 5:0 hold valid nonzero BCD (01 to 39). Otherwise the stored byte is unchanged.
- R6: Matching is evaluated only in a cycle where `tick` is high. A matching time without a tick sets nothing.
- R7: With all four mask bits clear, a tick hits only when seconds (bits 6:0), minutes (bits 6:0), hours (bits 5:0) and day (bits 5:0) all equal the alarm bytes.
- R8: With only the day mask set, a tick hits when hours, minutes and seconds match (daily).
- R9: With day and hours masks set, a tick hits when minutes and seconds match (hourly). With day, hours and minutes masks set, a tick hits when seconds match (every minute).
- R10: With all four masks set, or with any mask pattern other than the five listed, every tick hits.
- R11: A hit sets the flag, seen as `alarm_flag` and as status bit 6, whatever the enable bit. A read of the status register clears the flag. A hit in the same cycle as that read wins, and the flag stays set.
- R12: `alarm_irq` is high for exactly the one cycle after a ticked hit, and only if enable bit 7 was set at the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe once per second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD (24-hour) |
| now_date | input | 8 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
The assertions watch the following on every cycle:
- the stored alarm bytes always stay inside their legal BCD ranges;
- an interrupt pulse always follows a tick with the enable set, and always comes with the flag;
- the flag only rises after a tick;
- a status read with no tick empties the flag.

Only the bench scenarios can show which combinations of mask pattern and time fields hit and which miss. They also show that rejected writes leave the byte intact, and that a hit beats a simultaneous status read.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int FIELDS = 4;
  localparam int FLAG_BIT = 6;
  localparam int EN_BIT = 7;
  localparam int MASK_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_SEC    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MIN    = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_HOUR   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DATE   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_ENABLE = 3'd5;

  typedef enum logic [2:0] {
    RATE_MONTH, RATE_DAY, RATE_HOUR, RATE_MINUTE, RATE_SECOND
  } rate_e;

  // field index: 0 seconds, 1 minutes, 2 hours, 3 day
  typedef logic [FIELDS-1:0][DATA_W-1:0] field_vec_t;

  function automatic logic bcd_ok(input logic [6:0] v, input int unsigned lo,
                                  input int unsigned hi);
    int unsigned val;
    val = 32'(v[6:4]) * 10 + 32'(v[3:0]);
    return (v[3:0] <= 4'd9) && (val >= lo) && (val <= hi);
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output field_vec_t        alm,
  output logic              alarm_en
);
  logic accept_sec, accept_hour, accept_date;

  always_comb begin
    accept_sec  = bcd_ok(wr_data[6:0], 0, 59);
    accept_hour = bcd_ok({1'b0, wr_data[5:0]}, 0, 23);
    accept_date = bcd_ok({1'b0, wr_data[5:0]}, 1, 39);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm      <= {8'h01, 8'h00, 8'h00, 8'h00};
      alarm_en <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADR_SEC:    if (accept_sec)  alm[0] <= wr_data;
        ADR_MIN:    if (accept_sec)  alm[1] <= wr_data;
        ADR_HOUR:   if (accept_hour) alm[2] <= wr_data;
        ADR_DATE:   if (accept_date) alm[3] <= wr_data;
        ADR_ENABLE: alarm_en <= wr_data[EN_BIT];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  field_vec_t alm,
  input  field_vec_t now,
  output rate_e      rate,
  output logic       hit
);
  localparam field_vec_t KEEP = {8'h3F, 8'h3F, 8'h7F, 8'h7F};

  logic [FIELDS-1:0] eq;
  logic [FIELDS-1:0] masks;
  logic [FIELDS-1:0] need;

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    assign eq[i]    = ((alm[i] ^ now[i]) & KEEP[i]) == '0;
    assign masks[i] = alm[i][MASK_BIT];
  end

  always_comb begin
    unique case (masks)
      4'b0000: rate = RATE_MONTH;
      4'b1000: rate = RATE_DAY;
      4'b1100: rate = RATE_HOUR;
      4'b1110: rate = RATE_MINUTE;
      default: rate = RATE_SECOND;
    endcase
    unique case (rate)
      RATE_MONTH:  need = 4'b1111;
      RATE_DAY:    need = 4'b0111;
      RATE_HOUR:   need = 4'b0011;
      RATE_MINUTE: need = 4'b0001;
      default:     need = 4'b0000;
    endcase
    hit = &(eq | ~need);
  end
endmodule

// File: rtl/alarm_event.sv
module alarm_event (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic enable,
  input  logic clear,
  output logic flag,
  output logic irq
);
  logic fire;
  assign fire = tick && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= fire && enable;
      if (fire)       flag <= 1'b1;
      else if (clear) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] now_sec,
  input  logic [DATA_W-1:0] now_min,
  input  logic [DATA_W-1:0] now_hour,
  input  logic [DATA_W-1:0] now_date,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              alarm_flag,
  output logic              alarm_irq
);
  field_vec_t        alm_q;
  field_vec_t        now_v;
  logic              alarm_en_q;
  logic              hit;
  rate_e             rate;
  logic              status_clear;
  logic [DATA_W-1:0] rd_mux;

  assign now_v = {now_date, now_hour, now_min, now_sec};
  assign status_clear = rd_en && (rd_addr == ADR_STATUS);

  alarm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .alm(alm_q), .alarm_en(alarm_en_q)
  );

  alarm_match u_match (.alm(alm_q), .now(now_v), .rate(rate), .hit(hit));

  alarm_event u_event (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit), .enable(alarm_en_q),
    .clear(status_clear), .flag(alarm_flag), .irq(alarm_irq)
  );

  always_comb begin
    rd_mux = '0;
    unique case (rd_addr)
      ADR_STATUS: rd_mux[FLAG_BIT] = alarm_flag;
      ADR_SEC:    rd_mux = alm_q[0];
      ADR_MIN:    rd_mux = alm_q[1];
      ADR_HOUR:   rd_mux = alm_q[2];
      ADR_DATE:   rd_mux = alm_q[3];
      ADR_ENABLE: rd_mux[EN_BIT] = alarm_en_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/rtc_alarm_checker.sv
module rtc_alarm_checker
  import alarm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              irq,
  input logic              flag,
  input field_vec_t        alm,
  input logic              alarm_en
);
  assert_sec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_ok(alm[0][6:0], 0, 59) && bcd_ok(alm[1][6:0], 0, 59));

  assert_hour_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_ok({1'b0, alm[2][5:0]}, 0, 23));

  assert_date_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_ok({1'b0, alm[3][5:0]}, 1, 39));

  assert_flag_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));

  assert_irq_with_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADR_STATUS && !tick) |=> !flag);

  assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(tick) && $past(alarm_en)));
endmodule

bind rtc_alarm_match rtc_alarm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .rd_addr(rd_addr),
  .irq(alarm_irq), .flag(alarm_flag), .alm(alm_q), .alarm_en(alarm_en_q)
);

// File: tb/tb_rtc_alarm_match.sv
module tb_rtc_alarm_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00, now_date = 8'h01;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       alarm_flag, alarm_irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_alarm_match dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_date(now_date), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  // {a_sec, a_min, a_hour, a_date, t_sec, t_min, t_hour, t_date, expect}
  localparam int NV = 12;
  localparam logic [64:0] VEC [NV] = '{
    {8'h30, 8'h15, 8'h12, 8'h07, 8'h30, 8'h15, 8'h12, 8'h07, 1'b1},
    {8'h30, 8'h15, 8'h12, 8'h07, 8'h30, 8'h15, 8'h12, 8'h08, 1'b0},
    {8'h30, 8'h15, 8'h12, 8'h87, 8'h30, 8'h15, 8'h12, 8'h09, 1'b1},
    {8'h30, 8'h15, 8'h12, 8'h87, 8'h30, 8'h15, 8'h13, 8'h07, 1'b0},
    {8'h30, 8'h15, 8'h92, 8'h87, 8'h30, 8'h15, 8'h23, 8'h19, 1'b1},
    {8'h30, 8'h15, 8'h92, 8'h87, 8'h30, 8'h16, 8'h12, 8'h07, 1'b0},
    {8'h30, 8'h95, 8'h92, 8'h87, 8'h30, 8'h44, 8'h05, 8'h02, 1'b1},
    {8'h30, 8'h95, 8'h92, 8'h87, 8'h31, 8'h15, 8'h12, 8'h07, 1'b0},
    {8'hB0, 8'h95, 8'h92, 8'h87, 8'h01, 8'h02, 8'h03, 8'h04, 1'b1},
    {8'hB0, 8'h15, 8'h12, 8'h07, 8'h59, 8'h59, 8'h23, 8'h31, 1'b1},
    {8'h30, 8'h15, 8'h12, 8'h07, 8'h30, 8'h14, 8'h12, 8'h07, 1'b0},
    {8'h30, 8'h15, 8'h92, 8'h07, 8'h11, 8'h22, 8'h01, 8'h05, 1'b1}
  };
  localparam string VTAG [NV] = '{"R7", "R7", "R8", "R8", "R9", "R9",
                                  "R9", "R9", "R10", "R10", "R7", "R10"};

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_now(input logic [7:0] s, m, h, d);
    now_sec = s; now_min = m; now_hour = h; now_date = d;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {7'd0, alarm_irq}, 8'h00);
    check("R1 flag", {7'd0, alarm_flag}, 8'h00);
    rd(3'd0, v); check("R1 status", v, 8'h00);
    rd(3'd1, v); check("R1 sec", v, 8'h00);
    rd(3'd2, v); check("R1 min", v, 8'h00);
    rd(3'd3, v); check("R1 hour", v, 8'h00);
    rd(3'd4, v); check("R1 day", v, 8'h01);
    rd(3'd5, v); check("R1 enable", v, 8'h00);

    // R2 map details
    wr(3'd5, 8'hFF); rd(3'd5, v); check("R2 enable keeps bit7", v, 8'h80);
    wr(3'd0, 8'hFF); rd(3'd0, v); check("R2 status write ignored", v, 8'h00);
    rd(3'd6, v); check("R2 unmapped", v, 8'h00);

    // R3 seconds / minutes validation
    wr(3'd1, 8'h45); rd(3'd1, v); check("R3 sec accept", v, 8'h45);
    wr(3'd1, 8'h60); rd(3'd1, v); check("R3 sec 60 rejected", v, 8'h45);
    wr(3'd1, 8'h5A); rd(3'd1, v); check("R3 sec bad digit", v, 8'h45);
    wr(3'd1, 8'hD9); rd(3'd1, v); check("R3 sec with mask", v, 8'hD9);
    wr(3'd2, 8'h7F); rd(3'd2, v); check("R3 min rejected", v, 8'h00);

    // R4 hours validation
    wr(3'd3, 8'h23); rd(3'd3, v); check("R4 hour accept", v, 8'h23);
    wr(3'd3, 8'h24); rd(3'd3, v); check("R4 hour 24 rejected", v, 8'h23);
    wr(3'd3, 8'h1A); rd(3'd3, v); check("R4 hour bad digit", v, 8'h23);

    // R5 day validation
    wr(3'd4, 8'h00); rd(3'd4, v); check("R5 day zero rejected", v, 8'h01);
    wr(3'd4, 8'h31); rd(3'd4, v); check("R5 day accept", v, 8'h31);
    wr(3'd4, 8'h80); rd(3'd4, v); check("R5 masked zero rejected", v, 8'h31);

    // R6 matching time without a tick
    wr(3'd1, 8'h10); wr(3'd2, 8'h20); wr(3'd3, 8'h05); wr(3'd4, 8'h11);
    set_now(8'h10, 8'h20, 8'h05, 8'h11);
    repeat (5) @(negedge clk);
    check("R6 no tick no flag", {7'd0, alarm_flag}, 8'h00);
    check("R6 no tick no irq", {7'd0, alarm_irq}, 8'h00);

    // vector table: R7..R10 with enable set
    wr(3'd5, 8'h80);
    for (int i = 0; i < NV; i++) begin
      logic [64:0] e;
      e = VEC[i];
      wr(3'd1, e[64:57]); wr(3'd2, e[56:49]); wr(3'd3, e[48:41]); wr(3'd4, e[40:33]);
      set_now(e[32:25], e[24:17], e[16:9], e[8:1]);
      pulse_tick();
      check($sformatf("%s vec %0d irq", VTAG[i], i), {7'd0, alarm_irq}, {7'd0, e[0]});
      check($sformatf("%s vec %0d flag", VTAG[i], i), {7'd0, alarm_flag}, {7'd0, e[0]});
      rd(3'd0, v);
      check($sformatf("%s vec %0d status", VTAG[i], i), v, {1'b0, e[0], 6'd0});
    end

    // R12 pulse width and R11 read clears
    wr(3'd1, 8'hB0); wr(3'd2, 8'h95); wr(3'd3, 8'h92); wr(3'd4, 8'h87);
    pulse_tick();
    check("R12 irq high", {7'd0, alarm_irq}, 8'h01);
    @(negedge clk);
    check("R12 irq one cycle", {7'd0, alarm_irq}, 8'h00);
    check("R11 flag sticky", {7'd0, alarm_flag}, 8'h01);
    rd(3'd0, v);
    check("R11 status shows flag", v, 8'h40);
    check("R11 read cleared flag", {7'd0, alarm_flag}, 8'h00);

    // R12 / R11 enable off: flag but no pulse
    wr(3'd5, 8'h00);
    pulse_tick();
    check("R12 disabled no irq", {7'd0, alarm_irq}, 8'h00);
    check("R11 flag without enable", {7'd0, alarm_flag}, 8'h01);

    // R11 hit and status read in the same cycle: hit wins
    @(negedge clk);
    tick = 1'b1; rd_en = 1'b1; rd_addr = 3'd0;
    @(negedge clk);
    tick = 1'b0; rd_en = 1'b0;
    check("R11 set wins over clear", {7'd0, alarm_flag}, 8'h01);
    rd(3'd0, v);
    check("R11 cleared afterwards", {7'd0, alarm_flag}, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule